// File: doc/BRIEF.md
# Converter Fault Protection Supervisor

This block is the digital fault manager of a flyback power controller. It takes comparator flags that are already synchronized to its clock: supply undervoltage, supply overvoltage, an over-threshold flag from the protection pin, a peak-current-limit hit, a regulation-reached indication, a once-per-switching-cycle tick, a supply-ready pulse and a supply-reset condition. From these it decides whether the power switch may be driven, when a soft-start ramp is requested, and which of four operating modes the controller is in.

Three strap inputs set the behaviour. The first selects whether an overcurrent fault latches the controller off or triggers auto-recovery. The second enables pre-short arming. The third makes protection-pin detections recover automatically instead of latching. The analog hiccup of the supply rail is not modelled. It appears only as a recovery mode that is left after a fixed number of supply-ready pulses.

Pre-short arming protects against a shorted output at power-up. When both the latching overcurrent strap and the arming strap are set, the first drive pulse after power-up arms the block. Until regulation is reached, an undervoltage then latches the controller instead of starting auto-recovery.

Top module: `conv_fault_supervisor`

## Requirements
- R1: After reset `mode_o` is 0 (standby), and `drive_en_o` and `softstart_o` are low. A `supply_ready_i` pulse in standby moves the block to run (`mode_o` = 1) with `drive_en_o` high. `softstart_o` is high for exactly SS_CYCLES clocks, starting at the same edge.
- R2: In run, each `cycle_tick_i` that arrives with `prot_pin_i` high adds one to a consecutive count. A tick that arrives with `prot_pin_i` low clears the count. The LATCH_N-th consecutive tick moves the block to latched (`mode_o` = 3) when `strap_pin_autorec_i` is 0.
- R3: When `strap_pin_autorec_i` is 1, the same protection-pin detection moves the block to double-hiccup recovery (`mode_o` = 2) and never to latched.
- R4: Latched is left only when `vcc_reset_i` is high, and the block then goes to standby. Supply-ready, undervoltage, overvoltage and tick inputs have no effect while latched.
- R5: In run, `ov_i` that stays high for OVP_DELAY consecutive clocks moves the block to recovery at the OVP_DELAY-th edge. A shorter overvoltage episode has no effect.
- R6: In run, a `peak_hit_i` raises `fault_flag_o` and starts a window of FAULT_WIN clocks. If `peak_hit_i` is high at the last clock of the window, the block goes to latched when `strap_ocp_latch_i` = 1 and to recovery otherwise. If it is low, the flag and the window clear and the block stays in run.
- R7: When `strap_preshort_i` and `strap_ocp_latch_i` are both 1, the first `cycle_tick_i` in run after power-up arms the block. An undervoltage in run while armed goes straight to latched.
- R8: An undervoltage in run while not armed goes to recovery. Arming is cleared by `reg_ok_i` and happens at most once per power-up. Arming never occurs when `strap_ocp_latch_i` = 0.
- R9: In recovery, the block returns to run with soft-start one clock after the HICCUP_N-th `supply_ready_i` pulse, provided `ov_i` is low. While `ov_i` is high it stays in recovery.
- R10: `drive_en_o` is high only in run. It falls at the same edge at which latched or recovery is entered. If a latching cause and a recovery cause arrive together, latched wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uv_i | input | 1 | Supply undervoltage flag |
| ov_i | input | 1 | Supply overvoltage flag |
| prot_pin_i | input | 1 | Protection pin above its reference |
| peak_hit_i | input | 1 | Peak current limit reached |
| reg_ok_i | input | 1 | Output has reached regulation |
| cycle_tick_i | input | 1 | One-clock pulse per switching cycle (a drive pulse while running) |
| supply_ready_i | input | 1 | One-clock pulse when the supply reaches its start level |
| vcc_reset_i | input | 1 | Supply has fallen below its reset level |
| strap_ocp_latch_i | input | 1 | 1: overcurrent latches; 0: overcurrent auto-recovers |
| strap_preshort_i | input | 1 | Enables pre-short arming |
| strap_pin_autorec_i | input | 1 | 1: protection-pin detections auto-recover |
| drive_en_o | output | 1 | Power switch may be driven |
| softstart_o | output | 1 | Soft-start ramp requested |
| fault_flag_o | output | 1 | Overcurrent window in progress |
| mode_o | output | 2 | 0 standby, 1 run, 2 double-hiccup recovery, 3 latched |

## Verification
The bench builds the block with OVP_DELAY = 6, FAULT_WIN = 12, SS_CYCLES = 5, HICCUP_N = 2 and LATCH_N = 4. These small values let it hit each filter one clock short of firing and exactly at firing. They also let it watch the whole soft-start pulse and drive several recovery and power-cycle sequences within a short run. The default delays are much longer, but they use the same counters, so the edge timing the bench checks is the same for any parameter value.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'b00,
    MODE_RUN     = 2'b01,
    MODE_HICCUP  = 2'b10,
    MODE_LATCHED = 2'b11
  } cfs_mode_e;

  // Counter width able to hold the value n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Choose the destination of a running controller; latching takes precedence.
  function automatic cfs_mode_e fault_dest(input logic latch_req,
                                           input logic recover_req);
    if (latch_req)        return MODE_LATCHED;
    else if (recover_req) return MODE_HICCUP;
    else                  return MODE_RUN;
  endfunction

endpackage

// File: rtl/cfs_consec_counter.sv
module cfs_consec_counter #(
  parameter int unsigned N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic level_i,
  output logic fire_o
);
  import cfs_pkg::*;

  localparam int unsigned W = cnt_width(N);
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] cnt_q;
  logic         hit_w;
  logic         miss_w;

  assign hit_w  = en_i && tick_i && level_i;
  assign miss_w = en_i && tick_i && !level_i;
  assign fire_o = hit_w && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (miss_w)  cnt_q <= '0;
    else if (fire_o)  cnt_q <= '0;
    else if (hit_w)   cnt_q <= cnt_q + W'(1);
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2
  AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_w |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/cfs_fault_timer.sv
module cfs_fault_timer #(
  parameter int unsigned WIN = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic hit_i,
  output logic active_o,
  output logic fire_o
);
  import cfs_pkg::*;

  localparam int unsigned W = cnt_width(WIN);
  localparam logic [W-1:0] LAST = W'(WIN - 1);

  logic         active_q;
  logic [W-1:0] cnt_q;
  logic         expire_w;

  assign expire_w = en_i && active_q && (cnt_q == LAST);
  assign fire_o   = expire_w && hit_i;
  assign active_o = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!en_i || expire_w) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q    <= cnt_q + W'(1);
    end else if (hit_i) begin
      active_q <= 1'b1;
      cnt_q    <= W'(1);
    end
  end

  AST_FIRE_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> active_q); // R6
  AST_HIT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !active_q && hit_i |=> active_q); // R6

endmodule

// File: rtl/cfs_arm_tracker.sv
module cfs_arm_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic allow_i,
  input  logic drive_pulse_i,
  input  logic regulated_i,
  input  logic leave_run_i,
  input  logic power_cycle_i,
  output logic armed_o
);

  logic armed_q;
  logic spent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      spent_q <= 1'b0;
    end else if (power_cycle_i) begin
      armed_q <= 1'b0;
      spent_q <= 1'b0;
    end else if (leave_run_i || regulated_i) begin
      armed_q <= 1'b0;
    end else if (allow_i && drive_pulse_i && !spent_q) begin
      armed_q <= 1'b1;
      spent_q <= 1'b1;
    end
  end

  assign armed_o = armed_q;

  AST_ARM_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(allow_i)); // R8
  AST_ARM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    spent_q && !power_cycle_i |=> !$rose(armed_q)); // R8

endmodule

// File: rtl/conv_fault_supervisor.sv
module conv_fault_supervisor #(
  parameter int unsigned OVP_DELAY = 1000,
  parameter int unsigned FAULT_WIN = 2000,
  parameter int unsigned SS_CYCLES = 500,
  parameter int unsigned HICCUP_N  = 2,
  parameter int unsigned LATCH_N   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uv_i,
  input  logic       ov_i,
  input  logic       prot_pin_i,
  input  logic       peak_hit_i,
  input  logic       reg_ok_i,
  input  logic       cycle_tick_i,
  input  logic       supply_ready_i,
  input  logic       vcc_reset_i,
  input  logic       strap_ocp_latch_i,
  input  logic       strap_preshort_i,
  input  logic       strap_pin_autorec_i,
  output logic       drive_en_o,
  output logic       softstart_o,
  output logic       fault_flag_o,
  output logic [1:0] mode_o
);
  import cfs_pkg::*;

  localparam int unsigned SSW = cnt_width(SS_CYCLES);
  localparam int unsigned HCW = cnt_width(HICCUP_N);
  localparam logic [SSW-1:0] SS_LOAD  = SSW'(SS_CYCLES);
  localparam logic [HCW-1:0] HIC_DONE = HCW'(HICCUP_N);

  cfs_mode_e      state_q, state_d;
  logic [SSW-1:0] ss_cnt_q;
  logic [HCW-1:0] hic_cnt_q;

  // Named internal events
  logic run_w, pin_fire_w, ov_fire_w, oc_fire_w, oc_active_w, armed_w;
  logic latch_req_w, recover_req_w, restart_ok_w, enter_run_w, leave_run_w;
  logic power_cycle_w;

  assign run_w = (state_q == MODE_RUN);

  cfs_consec_counter #(.N(LATCH_N)) u_pin_count (
    .clk(clk), .rst_n(rst_n), .en_i(run_w), .tick_i(cycle_tick_i),
    .level_i(prot_pin_i), .fire_o(pin_fire_w)
  );

  cfs_consec_counter #(.N(OVP_DELAY)) u_ov_filter (
    .clk(clk), .rst_n(rst_n), .en_i(run_w), .tick_i(1'b1),
    .level_i(ov_i), .fire_o(ov_fire_w)
  );

  cfs_fault_timer #(.WIN(FAULT_WIN)) u_oc_timer (
    .clk(clk), .rst_n(rst_n), .en_i(run_w), .hit_i(peak_hit_i),
    .active_o(oc_active_w), .fire_o(oc_fire_w)
  );

  cfs_arm_tracker u_arm (
    .clk(clk), .rst_n(rst_n),
    .allow_i(strap_preshort_i && strap_ocp_latch_i),
    .drive_pulse_i(run_w && cycle_tick_i),
    .regulated_i(run_w && reg_ok_i),
    .leave_run_i(leave_run_w),
    .power_cycle_i(power_cycle_w),
    .armed_o(armed_w)
  );

  assign latch_req_w = run_w && ((uv_i && armed_w)
                               || (pin_fire_w && !strap_pin_autorec_i)
                               || (oc_fire_w && strap_ocp_latch_i));
  assign recover_req_w = run_w && (uv_i || pin_fire_w || ov_fire_w || oc_fire_w);
  assign restart_ok_w  = (state_q == MODE_HICCUP) && (hic_cnt_q == HIC_DONE) && !ov_i;
  assign power_cycle_w = (state_q == MODE_LATCHED) && vcc_reset_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MODE_STANDBY: if (supply_ready_i) state_d = MODE_RUN;
      MODE_RUN:     state_d = fault_dest(latch_req_w, recover_req_w);
      MODE_HICCUP:  if (restart_ok_w) state_d = MODE_RUN;
      MODE_LATCHED: if (vcc_reset_i) state_d = MODE_STANDBY;
      default:      state_d = MODE_STANDBY;
    endcase
  end

  assign enter_run_w = (state_q != MODE_RUN) && (state_d == MODE_RUN);
  assign leave_run_w = run_w && (state_d != MODE_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MODE_STANDBY;
    else        state_q <= state_d;
  end

  // Soft-start duration counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ss_cnt_q <= '0;
    else if (enter_run_w)           ss_cnt_q <= SS_LOAD;
    else if (!run_w)                ss_cnt_q <= '0;
    else if (ss_cnt_q != '0)        ss_cnt_q <= ss_cnt_q - SSW'(1);
  end

  // Supply-ready pulses seen during recovery
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hic_cnt_q <= '0;
    else if (state_q != MODE_HICCUP)  hic_cnt_q <= '0;
    else if (supply_ready_i && hic_cnt_q != HIC_DONE)
                                      hic_cnt_q <= hic_cnt_q + HCW'(1);
  end

  assign drive_en_o   = run_w;
  assign softstart_o  = run_w && (ss_cnt_q != '0);
  assign fault_flag_o = oc_active_w;
  assign mode_o       = state_q;

  AST_SS_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    softstart_o |-> drive_en_o); // R1
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_LATCHED) && !vcc_reset_i |=> (mode_o == 2'b11)); // R4
  AST_LATCH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_LATCHED) && vcc_reset_i |=> (mode_o == 2'b00)); // R4
  AST_DRIVE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    latch_req_w |=> !drive_en_o && (mode_o == 2'b11)); // R10
  AST_ARMED_UV: assert property (@(posedge clk) disable iff (!rst_n)
    run_w && armed_w && uv_i |=> (state_q == MODE_LATCHED)); // R7
  AST_RESTART_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_RUN) && ($past(state_q) == MODE_HICCUP)
      |-> ($past(hic_cnt_q) == HIC_DONE) && softstart_o); // R9

endmodule

// File: tb/conv_fault_supervisor_bench.sv
module conv_fault_supervisor_bench;

  localparam int OVP_D = 6;
  localparam int WIN   = 12;
  localparam int SS    = 5;
  localparam int HIC   = 2;
  localparam int LN    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv = 0, ov = 0, pin = 0, peak = 0, regok = 0, tick = 0, ready = 0, vres = 0;
  logic s_ocl = 0, s_pre = 0, s_auto = 0;
  logic drive, ss, flag;
  logic [1:0] mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  conv_fault_supervisor #(
    .OVP_DELAY(OVP_D), .FAULT_WIN(WIN), .SS_CYCLES(SS), .HICCUP_N(HIC), .LATCH_N(LN)
  ) u_conv_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .uv_i(uv), .ov_i(ov), .prot_pin_i(pin),
    .peak_hit_i(peak), .reg_ok_i(regok), .cycle_tick_i(tick),
    .supply_ready_i(ready), .vcc_reset_i(vres),
    .strap_ocp_latch_i(s_ocl), .strap_preshort_i(s_pre), .strap_pin_autorec_i(s_auto),
    .drive_en_o(drive), .softstart_o(ss), .fault_flag_o(flag), .mode_o(mode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ready();
    ready = 1; step(1); ready = 0;
  endtask

  task automatic do_tick(input logic p);
    tick = 1; pin = p; step(1); tick = 0; pin = 0;
  endtask

  task automatic power_cycle(input string tag);
    vres = 1; step(1); vres = 0;
    chk({tag, " standby after supply reset"}, mode, 0);
  endtask

  task automatic start(input string tag);
    pulse_ready();
    chk({tag, " run after start"}, mode, 1);
    chk({tag, " drive after start"}, drive, 1);
  endtask

  task automatic recover(input string tag);
    pulse_ready();
    chk({tag, " R9 still recovering after first ready"}, mode, 2);
    pulse_ready();
    chk({tag, " R9 still recovering at last ready edge"}, mode, 2);
    step(1);
    chk({tag, " R9 run after recovery"}, mode, 1);
    chk({tag, " R9 soft-start on restart"}, ss, 1);
  endtask

  task automatic t_reset();
    chk("R1 reset mode", mode, 0);
    chk("R1 reset drive", drive, 0);
    chk("R1 reset soft-start", ss, 0);
    start("R1");
    chk("R1 soft-start at entry", ss, 1);
    step(SS - 1);
    chk("R1 soft-start last clock", ss, 1);
    step(1);
    chk("R1 soft-start ended", ss, 0);
  endtask

  task automatic t_pin_latch();
    for (int i = 0; i < LN - 1; i++) do_tick(1);
    do_tick(0);
    for (int i = 0; i < LN - 1; i++) do_tick(1);
    chk("R2 broken run does not trip", mode, 1);
    do_tick(1);
    chk("R2 latched after consecutive ticks", mode, 3);
    chk("R10 drive low when latched", drive, 0);
    pulse_ready(); uv = 1; ov = 1; do_tick(1); step(3); uv = 0; ov = 0;
    chk("R4 latched ignores other inputs", mode, 3);
    chk("R4 drive stays low", drive, 0);
    power_cycle("R4");
    start("R4 restart");
  endtask

  task automatic t_pin_auto();
    s_auto = 1;
    for (int i = 0; i < LN; i++) do_tick(1);
    chk("R3 auto variant recovers", mode, 2);
    chk("R10 drive low in recovery", drive, 0);
    recover("R3");
    s_auto = 0;
  endtask

  task automatic t_ovp();
    ov = 1; step(OVP_D - 1); ov = 0; step(1);
    chk("R5 short overvoltage ignored", mode, 1);
    ov = 1; step(OVP_D - 1);
    chk("R5 one clock short", mode, 1);
    step(1);
    chk("R5 overvoltage accepted", mode, 2);
    pulse_ready(); pulse_ready(); step(2);
    chk("R9 held while overvoltage", mode, 2);
    ov = 0; step(1);
    chk("R9 resume when supply nominal", mode, 1);
  endtask

  task automatic t_ocp();
    s_ocl = 1;
    peak = 1; step(1); peak = 0;
    chk("R6 flag raised on hit", flag, 1);
    step(WIN + 2);
    chk("R6 window cleared without fault", flag, 0);
    chk("R6 still running", mode, 1);
    peak = 1; step(WIN - 1);
    chk("R6 one clock before expiry", mode, 1);
    step(1); peak = 0;
    chk("R6 latching variant latches", mode, 3);
    power_cycle("R6");
    s_ocl = 0;
    start("R6 auto");
    peak = 1; step(WIN); peak = 0;
    chk("R6 auto variant recovers", mode, 2);
    recover("R6");
  endtask

  task automatic t_preshort();
    s_ocl = 1; s_pre = 1;
    power_cycle_from_any();
    start("R7");
    do_tick(0);
    uv = 1; step(1); uv = 0;
    chk("R7 armed undervoltage latches", mode, 3);
    power_cycle("R7");
    start("R7 second");
    uv = 1; step(1); uv = 0;
    chk("R8 undervoltage before first pulse recovers", mode, 2);
    recover("R8");
    power_cycle_from_any();
    start("R8 reg");
    do_tick(0);
    regok = 1; step(1); regok = 0;
    uv = 1; step(1); uv = 0;
    chk("R8 regulation clears arming", mode, 2);
    recover("R8 reg");
    s_ocl = 0;
    power_cycle_from_any();
    start("R8 strap");
    do_tick(0);
    uv = 1; step(1); uv = 0;
    chk("R8 arming needs latching strap", mode, 2);
    s_pre = 0;
  endtask

  // Bring the block back to standby for a fresh power-up by latching it first.
  task automatic power_cycle_from_any();
    if (mode == 2) recover("pc");
    if (mode == 1) begin
      for (int i = 0; i < LN; i++) do_tick(1);
    end
    chk("R2 latched for power cycle", mode, 3);
    power_cycle("R4 pc");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    t_reset();
    t_pin_latch();
    t_pin_auto();
    t_ovp();
    t_ocp();
    t_preshort();
    finish_run();
  end

endmodule